// File: doc/BRIEF.md
# Prescaled Reload Timer with Toggle Output

The block divides a count stream in two cascaded stages. A prescaler counts down by one on each count and, one count after it reaches zero, reloads from its own reload register and passes one count to a second stage, the timer. The timer works the same way. When the timer reloads, it sets an interrupt request flag. A prescaler loaded with n and a timer loaded with m therefore raise one timer underflow every (n+1)(m+1) counts. A bus write to either stage writes its reload register and its live counter together. A read returns the live counter.

The prescaler input is picked by the operating mode. In timer mode and pulse mode it takes a count strobe from outside the block. In event mode it takes the active edges of an external event signal. In pulse mode a wave output changes level on every timer underflow. The wave starts at a level chosen by a polarity bit. An enable bit can put the inverted wave on a second pin. The interrupt flag stays set until software clears it.

Top module: `cascade_reload_timer`

## Requirements
- R1: After reset, both reload registers and both counters hold 0xFF, the control register reads 0x00, the interrupt flag is clear, and both wave pins are low.
- R2: The prescaler decrements by 1 on each count. On a count that finds it at 0 it reloads from its reload register and gives one count to the timer, so a loaded value n divides the count stream by n+1. Address 0 reads the live prescaler count.
- R3: The timer decrements by 1 on each prescaler underflow. On an underflow that finds it at 0 it reloads from its reload register, so a loaded value m gives one timer underflow per (n+1)(m+1) counts. Address 1 reads the live timer count.
- R4: A timer underflow sets the interrupt flag. The flag stays set until a write to address 3 with bit 0 equal to 0. A write with bit 0 equal to 1 leaves it set, and a set in the same cycle wins over a clear.
- R5: A write to address 0 or address 1 loads both the reload register and the live counter of that stage. If a count arrives in the same cycle, the write wins and the count is lost.
- R6: In pulse mode (control bits [1:0] = 01) the wave pin changes level on every timer underflow. Every control-register write sets the wave level to high when the polarity bit (bit 2) is 0 and to low when it is 1.
- R7: In pulse mode with the mirror bit (bit 3) set to 1, the second wave pin carries the inverse of the wave pin. With the mirror bit at 0, the second pin stays low.
- R8: Outside pulse mode, both wave pins stay low.
- R9: In event mode (bits [1:0] = 10) the prescaler counts rising edges of the event input when the polarity bit is 0 and falling edges when it is 1. The count strobe has no effect on the counters in this mode.
- R10: Mode 11 behaves exactly like timer mode (00): the prescaler counts strobes and both wave pins stay low.
- R11: Address 2 reads back the control register as {4'b0, mirror, polarity, mode[1:0]}, with the upper bits of a write discarded. Address 3 reads {7'b0, flag}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| count_stb | input | 1 | One-cycle count strobe, used in timer, pulse and reserved modes |
| evt_in | input | 1 | External event level, its edges counted in event mode |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 prescaler, 1 timer, 2 control, 3 flag |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr (combinational) |
| irq_req | output | 1 | Interrupt request flag |
| wave_out | output | 1 | Pulse-mode wave |
| wave_inv_out | output | 1 | Inverted copy of the wave when mirrored |

## Verification
The bench sweeps every combination of small prescaler and timer loads in timer mode and in reserved mode. It checks the live counts after every strobe against the closed-form values n - k mod (n+1) and m - floor(k/(n+1)) mod (m+1). A design that reloaded on reaching zero, rather than one count later, divides by n instead of n+1 and fails on the first reload. Load 0, the divide-by-one case, is the sharpest case for this. The pulse tests check the start level after each control write for both polarities, and the toggle point. A design that toggled on the prescaler underflow, or kept its old level after a polarity change, shows the wrong level on the first sample. Further tests cover a write that lands on a count, strobes arriving in event mode, the choice of edge by polarity, and a flag clear with bit 0 set. A design that let the count win, counted strobes in event mode, counted the wrong edge, or cleared on any write to address 3 gives a wrong count or a wrong flag.

// File: rtl/crt_pkg.sv
package crt_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER = 2'b00,
        MODE_PULSE = 2'b01,
        MODE_EVENT = 2'b10,
        MODE_RSVD  = 2'b11
    } crt_mode_e;

    localparam logic [1:0] ADDR_PRE  = 2'd0;
    localparam logic [1:0] ADDR_TMR  = 2'd1;
    localparam logic [1:0] ADDR_CTL  = 2'd2;
    localparam logic [1:0] ADDR_FLAG = 2'd3;

    localparam int CTL_W = 4;

    // control register layout: bit 3 mirror, bit 2 polarity, bits 1:0 mode
    typedef struct packed {
        logic      mirror;
        logic      pol;
        crt_mode_e mode;
    } crt_ctl_t;

endpackage

// File: rtl/crt_down_stage.sv
module crt_down_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] count,
    output logic         uf
);

    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] cnt;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        uf   = 1'b0;
        if (wr) begin
            st_d.latch = wdata;
            st_d.cnt   = wdata;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                uf       = 1'b1;
                st_d.cnt = st_q.latch;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

endmodule

// File: rtl/crt_count_src.sv
module crt_count_src (
    input  logic clk,
    input  logic rst_n,
    input  logic count_stb,
    input  logic evt_in,
    input  logic event_mode,
    input  logic fall_sel,
    output logic tick
);

    logic prev_d, prev_q;
    logic rise, fall;

    always_comb begin
        prev_d = evt_in;
        rise   = evt_in & ~prev_q;
        fall   = ~evt_in & prev_q;
        if (event_mode) begin
            tick = fall_sel ? fall : rise;
        end else begin
            tick = count_stb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end

endmodule

// File: rtl/crt_wave_gen.sv
module crt_wave_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic toggle,
    input  logic init,
    input  logic init_level,
    input  logic pulse_en,
    input  logic mirror_en,
    output logic wave_out,
    output logic wave_inv_out
);

    logic level_d, level_q;

    always_comb begin
        level_d = level_q;
        if (init) begin
            level_d = init_level;
        end else if (toggle) begin
            level_d = ~level_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
        end else begin
            level_q <= level_d;
        end
    end

    assign wave_out     = pulse_en & level_q;
    assign wave_inv_out = pulse_en & mirror_en & ~level_q;

endmodule

// File: rtl/cascade_reload_timer.sv
module cascade_reload_timer
    import crt_pkg::*;
#(
    parameter int PRE_W  = 8,
    parameter int TMR_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              count_stb,
    input  logic              evt_in,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_req,
    output logic              wave_out,
    output logic              wave_inv_out
);

    typedef struct packed {
        crt_ctl_t ctl;
        logic     flag;
    } top_t;

    top_t st_d, st_q;

    logic             pre_wr, tmr_wr, ctl_wr, flag_wr;
    logic             tick, pre_uf, tmr_uf;
    logic [PRE_W-1:0] pre_cnt;
    logic [TMR_W-1:0] tmr_cnt;
    logic             is_event, is_pulse;

    assign pre_wr  = bus_wr && (bus_addr == ADDR_PRE);
    assign tmr_wr  = bus_wr && (bus_addr == ADDR_TMR);
    assign ctl_wr  = bus_wr && (bus_addr == ADDR_CTL);
    assign flag_wr = bus_wr && (bus_addr == ADDR_FLAG);

    assign is_event = (st_q.ctl.mode == MODE_EVENT);
    assign is_pulse = (st_q.ctl.mode == MODE_PULSE);

    crt_count_src u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .count_stb  (count_stb),
        .evt_in     (evt_in),
        .event_mode (is_event),
        .fall_sel   (st_q.ctl.pol),
        .tick       (tick)
    );

    crt_down_stage #(.W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .wr    (pre_wr),
        .wdata (bus_wdata[PRE_W-1:0]),
        .count (pre_cnt),
        .uf    (pre_uf)
    );

    crt_down_stage #(.W(TMR_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (pre_uf),
        .wr    (tmr_wr),
        .wdata (bus_wdata[TMR_W-1:0]),
        .count (tmr_cnt),
        .uf    (tmr_uf)
    );

    crt_wave_gen u_wave (
        .clk          (clk),
        .rst_n        (rst_n),
        .toggle       (tmr_uf),
        .init         (ctl_wr),
        .init_level   (~bus_wdata[2]),
        .pulse_en     (is_pulse),
        .mirror_en    (st_q.ctl.mirror),
        .wave_out     (wave_out),
        .wave_inv_out (wave_inv_out)
    );

    always_comb begin
        st_d = st_q;
        if (ctl_wr) begin
            st_d.ctl = crt_ctl_t'(bus_wdata[CTL_W-1:0]);
        end
        if (tmr_uf) begin
            st_d.flag = 1'b1;
        end else if (flag_wr && !bus_wdata[0]) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_PRE:  bus_rdata[PRE_W-1:0] = pre_cnt;
            ADDR_TMR:  bus_rdata[TMR_W-1:0] = tmr_cnt;
            ADDR_CTL:  bus_rdata[CTL_W-1:0] = st_q.ctl;
            default:   bus_rdata[0]         = st_q.flag;
        endcase
    end

    assign irq_req = st_q.flag;

endmodule

// File: rtl/crt_checker.sv
module crt_checker
    import crt_pkg::*;
#(
    parameter int PRE_W  = 8,
    parameter int TMR_W  = 8,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [1:0]        bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              tick,
    input logic              pre_uf,
    input logic              tmr_uf,
    input logic [PRE_W-1:0]  pre_cnt,
    input logic [TMR_W-1:0]  tmr_cnt,
    input logic [1:0]        ctl_mode,
    input logic              ctl_mirror,
    input logic              irq_req,
    input logic              wave_out,
    input logic              wave_inv_out
);

    logic wr_pre, wr_tmr, wr_ctl, wr_clr;
    assign wr_pre = bus_wr && (bus_addr == ADDR_PRE);
    assign wr_tmr = bus_wr && (bus_addr == ADDR_TMR);
    assign wr_ctl = bus_wr && (bus_addr == ADDR_CTL);
    assign wr_clr = bus_wr && (bus_addr == ADDR_FLAG) && !bus_wdata[0];

    assert_pre_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_pre) |=> $stable(pre_cnt));

    assert_tmr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pre_uf && !wr_tmr) |=> $stable(tmr_cnt));

    assert_tmr_needs_pre_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_uf |-> pre_uf);

    assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !wr_clr) |=> irq_req);

    assert_flag_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(tmr_uf));

    assert_pre_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pre |=> (pre_cnt == $past(bus_wdata[PRE_W-1:0])));

    assert_tmr_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_tmr |=> (tmr_cnt == $past(bus_wdata[TMR_W-1:0])));

    assert_wave_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mode == MODE_PULSE && !tmr_uf && !wr_ctl) |=> $stable(wave_out));

    assert_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mode == MODE_PULSE && ctl_mirror) |-> (wave_inv_out == !wave_out));

    assert_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_mode != MODE_PULSE) |-> (!wave_out && !wave_inv_out));

endmodule

bind cascade_reload_timer crt_checker #(
    .PRE_W  (PRE_W),
    .TMR_W  (TMR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .tick         (tick),
    .pre_uf       (pre_uf),
    .tmr_uf       (tmr_uf),
    .pre_cnt      (pre_cnt),
    .tmr_cnt      (tmr_cnt),
    .ctl_mode     (st_q.ctl.mode),
    .ctl_mirror   (st_q.ctl.mirror),
    .irq_req      (irq_req),
    .wave_out     (wave_out),
    .wave_inv_out (wave_inv_out)
);

// File: tb/sim_cascade_reload_timer.sv
module sim_cascade_reload_timer;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       count_stb = 1'b0;
    logic       evt_in = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq_req, wave_out, wave_inv_out;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    cascade_reload_timer u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .count_stb    (count_stb),
        .evt_in       (evt_in),
        .bus_wr       (bus_wr),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq_req      (irq_req),
        .wave_out     (wave_out),
        .wave_inv_out (wave_inv_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int d);
        @(negedge clk);
        bus_addr = a;
        #1 d = int'(bus_rdata);
    endtask

    task automatic strobe();
        @(negedge clk);
        count_stb = 1'b1;
        @(negedge clk);
        count_stb = 1'b0;
    endtask

    task automatic evt(input logic v);
        @(negedge clk);
        evt_in = v;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int v;
        int exp_w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, v); chk("R1 pre", v, 255);
        rd(2'd1, v); chk("R1 tmr", v, 255);
        rd(2'd2, v); chk("R1 ctl", v, 0);
        rd(2'd3, v); chk("R1 flag", v, 0);
        chk("R1 wave", int'(wave_out), 0);
        chk("R1 inv", int'(wave_inv_out), 0);

        // R11 control readback drops upper bits
        wr(2'd2, 8'hF2);
        rd(2'd2, v); chk("R11 ctl readback", v, 8'h02);

        // R2 R3 R4 R10 sweep: mode 00 and reserved mode 11
        for (int md = 0; md < 4; md += 3) begin
            for (int n = 0; n < 4; n++) begin
                for (int m = 0; m < 4; m++) begin
                    wr(2'd2, 8'(md));
                    wr(2'd0, 8'(n));
                    wr(2'd1, 8'(m));
                    wr(2'd3, 8'h00);
                    for (int k = 1; k <= (n + 1) * (m + 1) + 2; k++) begin
                        strobe();
                        rd(2'd0, v);
                        chk(md == 0 ? "R2 pre count" : "R10 pre count", v, n - (k % (n + 1)));
                        rd(2'd1, v);
                        chk(md == 0 ? "R3 tmr count" : "R10 tmr count", v, m - ((k / (n + 1)) % (m + 1)));
                        chk("R4 flag", int'(irq_req), (k >= (n + 1) * (m + 1)) ? 1 : 0);
                        chk(md == 0 ? "R8 wave low" : "R10 wave low", int'(wave_out | wave_inv_out), 0);
                    end
                end
            end
        end

        // R4 flag clear rules (flag is set here)
        wr(2'd3, 8'h01);
        chk("R4 flag kept by bit0=1", int'(irq_req), 1);
        wr(2'd3, 8'h00);
        chk("R4 flag cleared", int'(irq_req), 0);

        // R5 write collides with a count
        wr(2'd2, 8'h00);
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h03);
        @(negedge clk);
        count_stb = 1'b1; bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h07;
        @(negedge clk);
        count_stb = 1'b0; bus_wr = 1'b0;
        rd(2'd0, v); chk("R5 write wins pre", v, 7);
        rd(2'd1, v); chk("R5 no underflow tmr", v, 3);
        strobe();
        rd(2'd0, v); chk("R5 latch loaded", v, 6);

        // R6 R7 pulse mode, polarity 0, mirror on
        wr(2'd0, 8'd1);
        wr(2'd1, 8'd1);
        wr(2'd2, 8'h09);
        for (int k = 0; k <= 12; k++) begin
            if (k > 0) strobe();
            exp_w = 1 ^ ((k / 4) & 1);
            chk("R6 wave pol0", int'(wave_out), exp_w);
            chk("R7 mirror", int'(wave_inv_out), 1 - exp_w);
        end

        // R6 R7 polarity 1, mirror off
        wr(2'd0, 8'd2);
        wr(2'd1, 8'd0);
        wr(2'd2, 8'h05);
        for (int k = 0; k <= 9; k++) begin
            if (k > 0) strobe();
            exp_w = (k / 3) & 1;
            chk("R6 wave pol1", int'(wave_out), exp_w);
            chk("R7 mirror off", int'(wave_inv_out), 0);
        end

        // R8 leave pulse mode
        wr(2'd2, 8'h08);
        for (int k = 0; k < 4; k++) begin
            strobe();
            chk("R8 wave quiet", int'(wave_out | wave_inv_out), 0);
        end

        // R9 event mode, rising edges
        wr(2'd2, 8'h02);
        wr(2'd0, 8'd5);
        wr(2'd1, 8'd9);
        repeat (3) strobe();
        rd(2'd0, v); chk("R9 strobe ignored", v, 5);
        for (int e = 1; e <= 3; e++) begin
            evt(1'b1);
            rd(2'd0, v); chk("R9 rising counted", v, 5 - e);
            evt(1'b0);
            rd(2'd0, v); chk("R9 falling ignored", v, 5 - e);
        end

        // R9 event mode, falling edges
        wr(2'd2, 8'h06);
        wr(2'd0, 8'd5);
        for (int e = 1; e <= 3; e++) begin
            evt(1'b1);
            rd(2'd0, v); chk("R9 rising ignored", v, 6 - e);
            evt(1'b0);
            rd(2'd0, v); chk("R9 falling counted", v, 5 - e);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule